// File: doc/BRIEF.md
# Framed Serial Word Deserializer

This block sits on the receive side of a serial link that carries parallel words as frames of 26 bits clocked by a forwarded bit clock. Each frame opens with a two-bit marker (a one, then a zero) and then carries 24 payload bits, least significant first. The block searches the stream for the marker, settles on a frame phase once that phase has proven itself, rebuilds each word and drives it on a parallel bus. A companion word strobe goes low when a new word lands and returns high half a frame later.

A parameter selects a variant for links whose top two payload positions are reserved. In that variant the two reserved received bits are thrown away, the two payload bits beneath them are moved up into the top two output positions, and the output positions they leave behind read zero.

When the enable input is low, the link is turned the other way. The receiver drops its frame lock and parks the word strobe high. The word bus keeps whatever it last held until a fresh word arrives after the link is turned back.

Top module: `frame_deser`

## Requirements
- R1: A frame is 26 consecutive bits on `serIn` sampled on rising `clk` edges: bit 0 is a one, bit 1 is a zero, and bits 2 to 25 are payload bits 0 to 23. In the default variant, `dataOut[k]` equals payload bit k of the frame loaded.
- R2: Lock is gained when the marker is seen at the end of two frames at the same bit phase, 26 cycles apart. The first word loaded is the frame that follows the second of these. The two frames that establish lock never change `dataOut`.
- R3: While locked, `dataOut` loads on the clock edge right after a frame with a correct marker ends. A frame with a wrong marker leaves `dataOut` unchanged and gives no strobe pulse.
- R4: One frame with a wrong marker, followed by a good one, keeps lock. Two frames in a row with a wrong marker drop lock, and the two following good frames then load nothing.
- R5: `wordClk` falls on the same edge that loads `dataOut`. It rises on the 13th clock edge after that one and stays high until the next load.
- R6: With `DEDICATED`=1, `dataOut[19:0]` takes payload bits 19:0, `dataOut[23:22]` takes payload bits 21:20, and `dataOut[21:20]` reads zero. Payload bits 23:22 are discarded.
- R7: While `enable` is low, `wordClk` is high from the next edge on and `dataOut` holds its value. Lock is cleared, so after `enable` returns high, words load only as R2 describes.
- R8: An active-low `rstN` drives `dataOut` to zero and `wordClk` high, and clears the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Forwarded bit clock; one serial bit is taken per rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High: receive direction; low: turned around, outputs held |
| serIn | input | 1 | Serial data stream |
| dataOut | output | DATA_W | Rebuilt parallel word |
| wordClk | output | 1 | Word strobe; falls with each new word, high when idle or disabled |

## Verification
The assertions check on every cycle that the word bus changes only on a strobe fall, that a strobe fall happens only while locked, that the strobe low phase lasts exactly half a frame unless a turn-around cuts it short, that a low enable freezes the bus and parks the strobe, and that the reserved outputs stay zero in the reserved-bit variant. The bench's scenarios are needed for what the actual bit stream decides. That covers the lock and loss of lock after two frames, a single bad marker that is tolerated, the relock after a turn-around, the exact word values under bit-walking and arithmetic payloads, and the remapping of the reserved positions.

// File: rtl/frx_pkg.sv
package frx_pkg;
  // frame synchronisation states
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } syncState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // turned around: flush shifter, park strobe
    logic load;     // capture the current frame into the word bus
    logic clkRise;  // half frame elapsed: raise the word strobe
  } frxCtl_t;
endpackage

// File: rtl/frx_datapath.sv
module frx_datapath
  import frx_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int BOUND_W   = 2,
  parameter bit DEDICATED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  frxCtl_t           ctl,
  output logic              frameMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic              wordClk
);
  localparam int FRAME_W = DATA_W + BOUND_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [DATA_W-1:0]  rxWord;
  logic [DATA_W-1:0]  mappedWord;

  // oldest bit sits at index 0 once a whole frame has entered
  assign rxWord     = shiftReg[FRAME_W-1:BOUND_W];
  assign frameMatch = shiftReg[0] && (shiftReg[BOUND_W-1:1] == '0);

  generate
    if (DEDICATED) begin : g_reserved
      // top two received bits are reserved: drop them, lift the two below
      assign mappedWord = {rxWord[DATA_W-3:DATA_W-4],
                           rxWord[DATA_W-1:DATA_W-2] & 2'b00,
                           rxWord[DATA_W-5:0]};
    end else begin : g_plain
      assign mappedWord = rxWord;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataOut  <= '0;
      wordClk  <= 1'b1;
    end else begin
      if (ctl.clear) shiftReg <= '0;
      else           shiftReg <= {serIn, shiftReg[FRAME_W-1:1]};

      if (ctl.load) dataOut <= mappedWord;

      if (ctl.clear)        wordClk <= 1'b1;
      else if (ctl.load)    wordClk <= 1'b0;
      else if (ctl.clkRise) wordClk <= 1'b1;
    end
  end
endmodule

// File: rtl/frx_control.sv
module frx_control
  import frx_pkg::*;
#(
  parameter int FRAME_W = 26
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    frameMatch,
  output frxCtl_t ctl,
  output logic    aligned
);
  localparam int                CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(FRAME_W / 2 - 1);

  syncState_t       state, stateNxt;
  logic [CNT_W-1:0] bitCnt;
  logic             missSeen, missNxt;
  logic             cntRestart, loadNow, tick;

  assign tick = (bitCnt == LAST_BIT);

  always_comb begin
    stateNxt   = state;
    missNxt    = missSeen;
    cntRestart = tick;
    loadNow    = 1'b0;
    unique case (state)
      ST_HUNT: begin
        if (frameMatch) begin
          stateNxt   = ST_CONFIRM;
          cntRestart = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (tick) stateNxt = frameMatch ? ST_LOCKED : ST_HUNT;
      end
      ST_LOCKED: begin
        if (tick) begin
          if (frameMatch) begin
            loadNow = 1'b1;
            missNxt = 1'b0;
          end else if (missSeen) begin
            stateNxt = ST_HUNT;
            missNxt  = 1'b0;
          end else begin
            missNxt = 1'b1;
          end
        end
      end
      default: stateNxt = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      bitCnt   <= '0;
      missSeen <= 1'b0;
    end else if (!enable) begin
      state    <= ST_HUNT;
      bitCnt   <= '0;
      missSeen <= 1'b0;
    end else begin
      state    <= stateNxt;
      bitCnt   <= cntRestart ? '0 : bitCnt + 1'b1;
      missSeen <= missNxt;
    end
  end

  always_comb begin
    ctl.clear   = !enable;
    ctl.load    = enable && loadNow;
    ctl.clkRise = enable && (bitCnt == HALF_M1);
  end

  assign aligned = (state == ST_LOCKED);
endmodule

// File: rtl/frame_deser.sv
module frame_deser
  import frx_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int BOUND_W   = 2,
  parameter bit DEDICATED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              serIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              wordClk
);
  localparam int FRAME_W = DATA_W + BOUND_W;

  frxCtl_t ctl;
  logic    frameMatch;
  logic    aligned;

  frx_control #(.FRAME_W(FRAME_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .frameMatch (frameMatch),
    .ctl        (ctl),
    .aligned    (aligned)
  );

  frx_datapath #(
    .DATA_W    (DATA_W),
    .BOUND_W   (BOUND_W),
    .DEDICATED (DEDICATED)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .serIn      (serIn),
    .ctl        (ctl),
    .frameMatch (frameMatch),
    .dataOut    (dataOut),
    .wordClk    (wordClk)
  );
endmodule

// File: rtl/frame_deser_chk.sv
module frame_deser_chk #(
  parameter int DATA_W    = 24,
  parameter int BOUND_W   = 2,
  parameter bit DEDICATED = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              wordClk,
  input logic [DATA_W-1:0] dataOut,
  input logic              aligned
);
  localparam int HALF = (DATA_W + BOUND_W) / 2;

  logic [7:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowCnt <= '0;
    else if (wordClk) lowCnt <= '0;
    else              lowCnt <= lowCnt + 8'd1;
  end

  // R3
  data_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $fell(wordClk));

  // R2
  load_when_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordClk) |-> $past(aligned));

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (wordClk && $stable(dataOut)));

  // R5
  low_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordClk |-> (lowCnt < HALF));

  // R5
  low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wordClk) && $past(enable)) |-> ($past(lowCnt) == HALF - 1));

  generate
    if (DEDICATED) begin : g_res_chk
      // R6
      reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        dataOut[DATA_W-3:DATA_W-4] == 2'b00);
    end
  endgenerate
endmodule

bind frame_deser frame_deser_chk #(
  .DATA_W    (DATA_W),
  .BOUND_W   (BOUND_W),
  .DEDICATED (DEDICATED)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .wordClk (wordClk),
  .dataOut (dataOut),
  .aligned (aligned)
);

// File: tb/frame_deser_tb_top.sv
`timescale 1ns/100ps
module frame_deser_tb_top;
  localparam int DW = 24;
  localparam int FW = 26;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, enable, serIn;
  logic [DW-1:0] outGen, outDed;
  logic          clkGen, clkDed;

  int  vecCnt = 0;
  int  errCnt = 0;
  bit  runDone = 1'b0;

  logic [DW-1:0] expData;
  bit            expPulse;

  frame_deser #(.DATA_W(DW), .BOUND_W(2), .DEDICATED(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .serIn(serIn),
    .dataOut(outGen), .wordClk(clkGen)
  );

  frame_deser #(.DATA_W(DW), .BOUND_W(2), .DEDICATED(1'b1)) dutDed_i (
    .clk(clk), .rstN(rstN), .enable(enable), .serIn(serIn),
    .dataOut(outDed), .wordClk(clkDed)
  );

  function automatic logic [DW-1:0] dedMap(input logic [DW-1:0] w);
    return {w[21:20], 2'b00, w[19:0]};
  endfunction

  task automatic checkWord(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Sends one frame; while it goes out, checks the outcome of the previous one.
  task automatic sendFrame(input logic [DW-1:0] d, input bit good, input string req);
    logic [FW-1:0] bits;
    bits = {d, good ? 2'b01 : 2'b00};
    for (int i = 0; i < FW; i++) begin
      @(negedge clk);
      if (i == 6) begin
        checkWord(req, outGen, expData);
        checkWord("R6", outDed, dedMap(expData));
        checkBit("R5", clkGen, !expPulse);
        checkBit("R5", clkDed, !expPulse);
      end
      if (expPulse && i == 13) checkBit("R5", clkGen, 1'b0);
      if (expPulse && i == 14) checkBit("R5", clkGen, 1'b1);
      serIn = bits[i];
    end
  endtask

  task automatic goodLoaded(input logic [DW-1:0] d, input string req);
    sendFrame(d, 1'b1, req);
    expData  = d;
    expPulse = 1'b1;
  endtask

  task automatic noLoad(input logic [DW-1:0] d, input bit good, input string req);
    sendFrame(d, good, req);
    expPulse = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!runDone) begin
      errCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] tmp;
    logic [DW-1:0] holdVal;
    rstN = 1'b0; enable = 1'b1; serIn = 1'b0;
    expData = '0; expPulse = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    checkWord("R8", outGen, '0);
    checkBit("R8", clkGen, 1'b1);
    rstN = 1'b1;

    // R2: two frames to gain lock, third is the first word
    noLoad(24'hA5C3F0, 1'b1, "R2");
    noLoad(24'h3C5A96, 1'b1, "R2");
    goodLoaded(24'h6B1E2D, "R2");

    // R1/R6 sweep: walking ones, then arithmetic payloads
    for (int k = 0; k < 48; k++) begin
      tmp = (k < DW) ? (32'd1 << k) : (32'(k) * 32'h009E3779 + 32'h00001234);
      goodLoaded(tmp[DW-1:0], "R1");
    end

    // R3: single wrong marker while locked, tolerated (R4)
    noLoad(24'hFFFFFF, 1'b0, "R1");
    goodLoaded(24'h0F0F0F, "R3");
    noLoad(24'h123456, 1'b0, "R1");
    goodLoaded(24'hC0FFEE, "R3");
    goodLoaded(24'h7E57AA, "R4");

    // R4: two wrong markers in a row drop lock
    noLoad(24'h13579B, 1'b0, "R4");
    noLoad(24'h000000, 1'b0, "R3");
    noLoad(24'h000000, 1'b1, "R4");
    noLoad(24'h000000, 1'b1, "R4");
    goodLoaded(24'h5A5A5A, "R4");
    goodLoaded(24'h2468AC, "R4");

    // flush last word: two more edges load it
    @(negedge clk); serIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkWord("R3", outGen, 24'h2468AC);
    holdVal = outGen;

    // R7: turn around
    enable = 1'b0;
    @(negedge clk);
    checkBit("R7", clkGen, 1'b1);
    checkBit("R7", clkDed, 1'b1);
    for (int f = 0; f < 3; f++) begin
      tmp = {8'h00, 24'h9B1D33} ^ (32'(f) << 5);
      for (int i = 0; i < FW; i++) begin
        @(negedge clk);
        serIn = (i == 0) ? 1'b1 : (i == 1) ? 1'b0 : tmp[i-2];
      end
    end
    @(negedge clk);
    checkWord("R7", outGen, holdVal);
    checkWord("R7", outDed, dedMap(holdVal));
    checkBit("R7", clkGen, 1'b1);
    serIn = 1'b0;
    enable = 1'b1;
    expData = holdVal; expPulse = 1'b0;

    // R7: relock needs two frames again
    noLoad(24'h314159, 1'b1, "R7");
    noLoad(24'h265358, 1'b1, "R7");
    goodLoaded(24'h979323, "R7");
    goodLoaded(24'h846264, "R7");
    noLoad(24'h000000, 1'b1, "R7");

    // R8: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkWord("R8", outGen, '0);
    checkWord("R8", outDed, '0);
    checkBit("R8", clkGen, 1'b1);
    rstN = 1'b1;

    runDone = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule